// File: doc/BRIEF.md
# Register-Mapped Word FIFO with Sticky Error Flags

This block is a 32-bit first-in first-out buffer reached through a simple register bus. The bus has separate read and write strobes, a byte offset address and four byte enables. A write to the data location stores one word at the tail, and a read from it returns and removes the word at the head. Read data is combinational: it is valid in the same cycle as the read strobe, and the pop takes effect at the next rising clock edge. Both strobes may be raised in the same cycle at the data location, which performs a push and a pop together.

A status location reports the occupancy flags (empty, full), two alarm levels (high and low) set against a programmable threshold, and sticky error flags for underflow, overflow and partial byte-enable access to the data port. A summary error bit is the OR of the sticky flags. Writing 1 to it clears all of them, but only when the fault that caused a flag is no longer present. A control location offers a flush, and the read and write pointers can be read back. The depth is a parameter, 16 words by default.

Top module: `wqf_top`

## Requirements
- R1: A write with all byte enables to offset 0x3C pushes the write data. A read with all byte enables from 0x3C returns the oldest stored word in the same cycle and removes it at the following clock edge, in first-in first-out order.
- R2: The status register at offset 0x40 has, counted from bit 0 as the least significant bit, Err at 22, UF at 21, OF at 20, Full at 19, HI at 18, LO at 17 and Empty at 16. Every other bit reads 0.
- R3: A pop when the FIFO is empty sets UF, returns 0 and leaves the read pointer unchanged.
- R4: A push when the FIFO is full and no pop happens in the same cycle sets OF, drops the data and leaves the write pointer unchanged.
- R5: A read or write at 0x3C whose byte enables are not all 1 causes no push or pop and returns 0. It sets a sticky access-error flag that is visible only through Err.
- R6: UF, OF and the access error are sticky, and Err reads as their OR. A write to 0x40 with byte enable 2 set and write data bit 22 set clears all three. The clear is ignored while UF is set and the FIFO is empty, or while OF is set and the FIFO is full.
- R7: The alarm threshold is the low bits of the register at 0x48, which reads back as written. HI is set when the fill level is at or above the threshold. LO is set when the fill level plus the threshold is at most the depth, so LO is never set for a threshold above the depth.
- R8: A push and a pop in the same cycle on a non-empty FIFO leave the fill level unchanged. When the FIFO is full, neither is refused and OF is not set. When the FIFO is empty, the pop underflows and the push is stored.
- R9: The registers at 0x4C (read pointer) and 0x50 (write pointer) return the internal pointers, zero-extended. Writes to them have no effect.
- R10: A write to 0x44 with byte enable 0 and data bit 0 set empties the FIFO and sets both pointers to 0. Offset 0x44 always reads 0.
- R11: After reset the pointers, fill level, sticky flags and threshold are 0, so status reads 0x0007_0000 (Empty, LO and HI).
- R12: A read from any unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset; bits 1:0 are ignored |
| bus_be | input | 4 | Byte enables, one per byte lane |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from state and bus inputs |

## Verification
A push and a pop can fall in the same cycle at the data port. The bench provokes this by raising both strobes in one access: once on a partly filled FIFO, and once on a full FIFO that already has OF set. In each case it judges the returned head word, the pointer registers afterwards and the status word, and it expects an unchanged fill level and no refused push. A flag clear and the condition that blocks it also meet in one cycle: the bench issues the clear while the FIFO is still empty or still full, confirms that Err stays set, and then repeats the clear once the condition has gone.

// File: rtl/wqf_pkg.sv
package wqf_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int BE_W   = DATA_W / 8;

    localparam logic [ADDR_W-1:0] OFF_DATA = 8'h3C;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_ALRM = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_RPTR = 8'h4C;
    localparam logic [ADDR_W-1:0] OFF_WPTR = 8'h50;

    localparam int ST_ERR  = 22;
    localparam int ST_UF   = 21;
    localparam int ST_OF   = 20;
    localparam int ST_FULL = 19;
    localparam int ST_HI   = 18;
    localparam int ST_LO   = 17;
    localparam int ST_EMP  = 16;

    typedef struct packed {
        logic push;
        logic pop;
        logic bad;
        logic clr;
        logic flush;
    } bus_evt_t;
endpackage

// File: rtl/wqf_store.sv
module wqf_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/wqf_ctrl.sv
module wqf_ctrl #(
    parameter int DEPTH  = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wqf_pkg::bus_evt_t ev,
    output logic              push_ok,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [CNT_W-1:0]  level,
    output logic              uf,
    output logic              of,
    output logic              ae
);
    localparam logic [CNT_W-1:0] LVL_MAX = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] rp;
        logic [PTR_W-1:0] wp;
        logic [CNT_W-1:0] lvl;
        logic             uf;
        logic             of;
        logic             ae;
    } state_t;

    state_t st_q, st_d;
    logic   empty, full, pop_ok, pop_uf, push_of, clr_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_TOP) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        empty   = (st_q.lvl == '0);
        full    = (st_q.lvl == LVL_MAX);
        pop_ok  = ev.pop && !empty;
        pop_uf  = ev.pop && empty;
        push_ok = ev.push && (!full || pop_ok);
        push_of = ev.push && !push_ok;
        clr_ok  = ev.clr && !(st_q.uf && empty) && !(st_q.of && full);

        if (pop_ok) begin
            st_d.rp = bump(st_q.rp);
        end
        if (push_ok) begin
            st_d.wp = bump(st_q.wp);
        end
        st_d.lvl = st_q.lvl + CNT_W'(push_ok) - CNT_W'(pop_ok);

        if (ev.flush) begin
            st_d.rp  = '0;
            st_d.wp  = '0;
            st_d.lvl = '0;
        end

        st_d.uf = (st_q.uf && !clr_ok) || pop_uf;
        st_d.of = (st_q.of && !clr_ok) || push_of;
        st_d.ae = (st_q.ae && !clr_ok) || ev.bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ptr = st_q.rp;
    assign wr_ptr = st_q.wp;
    assign level  = st_q.lvl;
    assign uf     = st_q.uf;
    assign of     = st_q.of;
    assign ae     = st_q.ae;
endmodule

// File: rtl/wqf_regif.sv
module wqf_regif #(
    parameter int DEPTH  = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [wqf_pkg::ADDR_W-1:0]   bus_addr,
    input  logic [wqf_pkg::BE_W-1:0]     bus_be,
    input  logic [wqf_pkg::DATA_W-1:0]   bus_wdata,
    input  logic [PTR_W-1:0]             rd_ptr,
    input  logic [PTR_W-1:0]             wr_ptr,
    input  logic [CNT_W-1:0]             level,
    input  logic                         uf,
    input  logic                         of,
    input  logic                         ae,
    input  logic [wqf_pkg::DATA_W-1:0]   head,
    output wqf_pkg::bus_evt_t            ev,
    output logic [wqf_pkg::DATA_W-1:0]   bus_rdata
);
    import wqf_pkg::*;

    localparam int WORD_W = ADDR_W - 2;
    localparam logic [CNT_W:0] DEPTH_X = (CNT_W + 1)'(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0] thr;
    } cfg_t;

    cfg_t              cfg_q, cfg_d;
    logic [WORD_W-1:0] word;
    logic              sel_data, sel_stat, sel_ctrl, sel_alrm;
    logic              be_full, empty, full, hi, lo;
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        word     = bus_addr[ADDR_W-1:2];
        sel_data = (word == OFF_DATA[ADDR_W-1:2]);
        sel_stat = (word == OFF_STAT[ADDR_W-1:2]);
        sel_ctrl = (word == OFF_CTRL[ADDR_W-1:2]);
        sel_alrm = (word == OFF_ALRM[ADDR_W-1:2]);
        be_full  = &bus_be;

        ev.push  = bus_wr && sel_data && be_full;
        ev.pop   = bus_rd && sel_data && be_full;
        ev.bad   = (bus_wr || bus_rd) && sel_data && !be_full;
        ev.clr   = bus_wr && sel_stat && bus_be[ST_ERR/8] && bus_wdata[ST_ERR];
        ev.flush = bus_wr && sel_ctrl && bus_be[0] && bus_wdata[0];

        cfg_d = cfg_q;
        if (bus_wr && sel_alrm && bus_be[0]) begin
            cfg_d.thr = bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        empty = (level == '0);
        full  = (level == CNT_W'(DEPTH));
        hi    = (level >= cfg_q.thr);
        lo    = ({1'b0, level} + {1'b0, cfg_q.thr}) <= DEPTH_X;

        stat_word          = '0;
        stat_word[ST_ERR]  = uf || of || ae;
        stat_word[ST_UF]   = uf;
        stat_word[ST_OF]   = of;
        stat_word[ST_FULL] = full;
        stat_word[ST_HI]   = hi;
        stat_word[ST_LO]   = lo;
        stat_word[ST_EMP]  = empty;

        bus_rdata = '0;
        unique case (bus_addr[ADDR_W-1:2])
            OFF_DATA[ADDR_W-1:2]: bus_rdata = (be_full && !empty) ? head : '0;
            OFF_STAT[ADDR_W-1:2]: bus_rdata = stat_word;
            OFF_ALRM[ADDR_W-1:2]: bus_rdata = DATA_W'(cfg_q.thr);
            OFF_RPTR[ADDR_W-1:2]: bus_rdata = DATA_W'(rd_ptr);
            OFF_WPTR[ADDR_W-1:2]: bus_rdata = DATA_W'(wr_ptr);
            default:              bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wqf_top.sv
module wqf_top #(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    wqf_pkg::bus_evt_t ev;
    logic              push_ok;
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  level;
    logic              uf, of, ae;
    logic [31:0]       head;

    wqf_regif #(.DEPTH(DEPTH)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .rd_ptr    (rd_ptr),
        .wr_ptr    (wr_ptr),
        .level     (level),
        .uf        (uf),
        .of        (of),
        .ae        (ae),
        .head      (head),
        .ev        (ev),
        .bus_rdata (bus_rdata)
    );

    wqf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .push_ok (push_ok),
        .rd_ptr  (rd_ptr),
        .wr_ptr  (wr_ptr),
        .level   (level),
        .uf      (uf),
        .of      (of),
        .ae      (ae)
    );

    wqf_store #(.DEPTH(DEPTH), .DATA_W(32)) u_store (
        .clk   (clk),
        .we    (push_ok),
        .waddr (wr_ptr),
        .wdata (bus_wdata),
        .raddr (rd_ptr),
        .rdata (head)
    );
endmodule

// File: rtl/wqf_checker.sv
module wqf_checker #(
    parameter int DEPTH  = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push,
    input logic             pop,
    input logic             bad,
    input logic             clr,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [CNT_W-1:0] level,
    input logic             uf,
    input logic             of,
    input logic             ae
);
    // R1
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    // R3
    uf_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && level == '0) |=> (uf && $stable(rd_ptr)));

    // R4
    of_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level == CNT_W'(DEPTH)) |=> (of && $stable(wr_ptr)));

    // R5
    bad_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> (ae && $stable(level)));

    // R6
    sticky_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && !clr) |=> uf);

    // R6
    sticky_of_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (of && !clr) |=> of);

    // R8
    push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && level != '0) |=> $stable(level));
endmodule

bind wqf_top wqf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (ev.push),
    .pop    (ev.pop),
    .bad    (ev.bad),
    .clr    (ev.clr),
    .rd_ptr (rd_ptr),
    .wr_ptr (wr_ptr),
    .level  (level),
    .uf     (uf),
    .of     (of),
    .ae     (ae)
);

// File: tb/tb_wqf_top.sv
`timescale 1ns/1ps
module tb_wqf_top;
    localparam int NVEC = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wqf_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // {wr, rd, addr, be, wdata, expected read data}
    localparam logic [77:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 8'h40, 4'hF, 32'h0,  32'h0007_0000},
        {1'b1, 1'b0, 8'h48, 4'hF, 32'd4,  32'h0},
        {1'b0, 1'b1, 8'h48, 4'hF, 32'h0,  32'd4},
        {1'b1, 1'b0, 8'h3C, 4'hF, 32'hA1, 32'h0},
        {1'b1, 1'b0, 8'h3C, 4'hF, 32'hA2, 32'h0},
        {1'b1, 1'b0, 8'h3C, 4'hF, 32'hA3, 32'h0},
        {1'b0, 1'b1, 8'h40, 4'hF, 32'h0,  32'h0002_0000},
        {1'b1, 1'b0, 8'h3C, 4'hF, 32'hA4, 32'h0},
        {1'b0, 1'b1, 8'h40, 4'hF, 32'h0,  32'h0006_0000},
        {1'b0, 1'b1, 8'h3C, 4'hF, 32'h0,  32'hA1},
        {1'b0, 1'b1, 8'h50, 4'hF, 32'h0,  32'd4},
        {1'b0, 1'b1, 8'h4C, 4'hF, 32'h0,  32'd1},
        {1'b1, 1'b1, 8'h3C, 4'hF, 32'hA5, 32'hA2},
        {1'b0, 1'b1, 8'h4C, 4'hF, 32'h0,  32'd2},
        {1'b0, 1'b1, 8'h50, 4'hF, 32'h0,  32'd5}
    };

    function automatic logic [31:0] st(input bit err, input bit uf, input bit of,
                                       input bit full, input bit hi, input bit lo,
                                       input bit emp);
        return {9'b0, err, uf, of, full, hi, lo, emp, 16'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input bit rd, input logic [7:0] addr,
                       input logic [3:0] be, input logic [31:0] wd,
                       output logic [31:0] rdv);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_be = be; bus_wdata = wd;
        #1;
        rdv = bus_rdata;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [7:0] addr, input logic [31:0] exp);
        logic [31:0] v;
        acc(1'b0, 1'b1, addr, 4'hF, 32'h0, v);
        check(req, v, exp);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [3:0] be, input logic [31:0] wd);
        logic [31:0] v;
        acc(1'b1, 1'b0, addr, be, wd, v);
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 R2 R7 R8 R9 R11: vector table
        for (int i = 0; i < NVEC; i++) begin
            acc(VEC[i][77], VEC[i][76], VEC[i][75:68], VEC[i][67:64], VEC[i][63:32], v);
            if (VEC[i][76]) check($sformatf("R1/R2/R7/R8/R9/R11 vector %0d", i), v, VEC[i][31:0]);
        end

        // R1: drain remaining words in order
        rchk("R1 order", 8'h3C, 32'hA3);
        rchk("R1 order", 8'h3C, 32'hA4);
        rchk("R1 order", 8'h3C, 32'hA5);

        // R3: pop on empty
        rchk("R3 empty pop data", 8'h3C, 32'h0);
        rchk("R3 read pointer held", 8'h4C, 32'd5);
        rchk("R3 status", 8'h40, st(1, 1, 0, 0, 0, 1, 1));

        // R6: clear blocked while still empty, accepted after a push
        wr(8'h40, 4'hF, 32'h0040_0000);
        rchk("R6 clear blocked while empty", 8'h40, st(1, 1, 0, 0, 0, 1, 1));
        wr(8'h3C, 4'hF, 32'hB0);
        rchk("R6 after push", 8'h40, st(1, 1, 0, 0, 0, 1, 0));
        wr(8'h40, 4'hF, 32'h0040_0000);
        rchk("R6 clear accepted", 8'h40, st(0, 0, 0, 0, 0, 1, 0));

        // R5: partial byte enables on write and read
        wr(8'h3C, 4'h7, 32'hCC);
        rchk("R5 partial write not stored", 8'h50, 32'd6);
        rchk("R5 err only", 8'h40, st(1, 0, 0, 0, 0, 1, 0));
        wr(8'h40, 4'h4, 32'h0040_0000);
        rchk("R6 access error cleared", 8'h40, st(0, 0, 0, 0, 0, 1, 0));
        acc(1'b0, 1'b1, 8'h3C, 4'h3, 32'h0, v);
        check("R5 partial read data", v, 32'h0);
        rchk("R5 partial read no pop", 8'h4C, 32'd5);
        wr(8'h40, 4'hF, 32'h0040_0000);

        // R4: fill to full then overflow
        for (int i = 0; i < 15; i++) wr(8'h3C, 4'hF, 32'h100 + i);
        rchk("R4 full status", 8'h40, st(0, 0, 0, 1, 1, 0, 0));
        rchk("R9 write pointer wrapped", 8'h50, 32'd5);
        wr(8'h3C, 4'hF, 32'hDEAD);
        rchk("R4 write pointer held", 8'h50, 32'd5);
        rchk("R4 overflow status", 8'h40, st(1, 0, 1, 1, 1, 0, 0));
        wr(8'h40, 4'hF, 32'h0040_0000);
        rchk("R6 clear blocked while full", 8'h40, st(1, 0, 1, 1, 1, 0, 0));

        // R8: push and pop together on a full FIFO
        acc(1'b1, 1'b1, 8'h3C, 4'hF, 32'hE0, v);
        check("R8 head at full", v, 32'hB0);
        rchk("R8 write pointer moved", 8'h50, 32'd6);
        rchk("R8 still full", 8'h40, st(1, 0, 1, 1, 1, 0, 0));
        rchk("R1 next word", 8'h3C, 32'h100);
        rchk("R4 after pop", 8'h40, st(1, 0, 1, 0, 1, 0, 0));
        wr(8'h40, 4'hF, 32'h0040_0000);
        rchk("R6 clear after fault gone", 8'h40, st(0, 0, 0, 0, 1, 0, 0));

        // R9: pointer registers ignore writes
        wr(8'h4C, 4'hF, 32'h3);
        rchk("R9 read pointer unchanged", 8'h4C, 32'd7);

        // R10: flush
        wr(8'h44, 4'hF, 32'h1);
        rchk("R10 read pointer", 8'h4C, 32'd0);
        rchk("R10 write pointer", 8'h50, 32'd0);
        rchk("R10 status", 8'h40, st(0, 0, 0, 0, 0, 1, 1));
        rchk("R10 control reads 0", 8'h44, 32'h0);

        // R12: unmapped
        rchk("R12 unmapped", 8'h00, 32'h0);
        rchk("R12 unmapped", 8'h54, 32'h0);

        // R7: threshold above depth clears LO
        wr(8'h48, 4'hF, 32'd20);
        rchk("R7 threshold readback", 8'h48, 32'd20);
        rchk("R7 LO off above depth", 8'h40, st(0, 0, 0, 0, 0, 0, 1));

        // R11: reset mid-run
        wr(8'h3C, 4'hF, 32'h77);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        rchk("R11 status after reset", 8'h40, st(0, 0, 0, 0, 1, 1, 1));
        rchk("R11 threshold after reset", 8'h48, 32'h0);
        rchk("R11 write pointer after reset", 8'h50, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule